// File: doc/BRIEF.md
# Indirect Address/Data Access Window

This block gives a host a narrow 32-byte I/O window into a much larger internal address space. It has two 32-bit registers. The pointer register holds a 20-bit internal target address. Accesses to the data register are passed through to whatever that pointer selects. Pointer values at the bottom of the space select a register/memory port. Pointer values in the upper half select a flash port. Pointer values in the gap between the two select nothing.

The host bus carries a request valid, a write flag, a byte offset, four byte enables and write data. It returns read data and a one-cycle ready pulse. The host keeps its request steady until ready arrives. The window claims a request only while the I/O base is marked non-zero and I/O decoding is enabled.

A controller state machine sequences every access through these states:
- `ST_IDLE` waits for a claimed request. It moves to `ST_RESP` for pointer accesses, unused offsets, gap targets and dropped writes. It moves to `ST_ISSUE` for data accesses that are forwarded.
- `ST_ISSUE` raises the single-cycle strobe. It goes to `ST_RESP` if the port acknowledges in that cycle, and to `ST_WAIT` otherwise.
- `ST_WAIT` holds until the acknowledge arrives, then goes to `ST_RESP`.
- `ST_RESP` presents ready and the captured data, and always returns to `ST_IDLE`.

Top module: `indirect_win`

## Requirements
- R1: Byte offsets 0x00 (pointer) and 0x04 (data) are the only live words. Every other offset in the 32-byte window reads as zero, ignores writes and raises no internal strobe.
- R2: While `io_base_nz` or `io_dec_en` is low, a request gets no ready, changes no state and raises no strobe.
- R3: A pointer write with all four byte enables loads bits 19:0. Bits 31:20 always read back as zero.
- R4: A pointer write with any byte enable low is discarded.
- R5: The pointer is zero after either `pwr_rst_n` or `bus_rst_n` is asserted. Otherwise it keeps its value until the next full-width write.
- R6: A read of either register returns the full 32-bit word whatever the byte enables are.
- R7: With a pointer in 0x00000–0x1FFFF, a data access raises `rm_rd` or `rm_wr` with `rm_addr` equal to the pointer. A read returns `rm_rdata` captured at `rm_ack`.
- R8: With a pointer in 0x80000–0xFFFFF, a data access raises `fl_rd` or `fl_wr`. Writes carry `fl_be` unchanged, so partial writes reach the flash port.
- R9: With a pointer in the register/memory range, a data write whose byte enables are not all set is dropped: no strobe is raised, but ready still pulses.
- R10: With a pointer in 0x20000–0x7FFFF, a data access raises no strobe and reads as zero.
- R11: Ready is a one-cycle pulse. The first host-side clock edge is counted as one.
  - A local access responds after one edge.
  - A forwarded access responds one edge after the port acknowledge.
  - A flash port that acknowledges in the strobe cycle gives 2 edges.
  - A register/memory port that acknowledges one cycle later gives 3 edges.
- R12: Each forwarded access raises exactly one strobe for exactly one cycle. At most one of the four strobes is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-good reset, active low, asynchronous |
| bus_rst_n | input | 1 | Host bus reset, active low, asynchronous |
| io_base_nz | input | 1 | I/O base is allocated and non-zero |
| io_dec_en | input | 1 | I/O decoding enabled |
| h_valid | input | 1 | Host request valid, held until ready |
| h_we | input | 1 | Host write (1) or read (0) |
| h_off | input | 5 | Byte offset within the window |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_ready | output | 1 | One-cycle completion pulse |
| h_rdata | output | 32 | Read data, valid with h_ready |
| rm_addr | output | ADDR_W | Register/memory port address |
| rm_rd | output | 1 | Register/memory read strobe |
| rm_wr | output | 1 | Register/memory write strobe |
| rm_wdata | output | 32 | Register/memory write data |
| rm_rdata | input | 32 | Register/memory read data |
| rm_ack | input | 1 | Register/memory acknowledge |
| fl_addr | output | ADDR_W | Flash port address |
| fl_rd | output | 1 | Flash read strobe |
| fl_wr | output | 1 | Flash write strobe |
| fl_be | output | 4 | Flash write byte enables |
| fl_wdata | output | 32 | Flash write data |
| fl_rdata | input | 32 | Flash read data |
| fl_ack | input | 1 | Flash acknowledge |

## Verification
The bench builds the block with its defaults: a 20-bit pointer, a register/memory range ending at 0x1FFFF and flash starting at 0x80000. Those values put addresses in every region within reach of a handful of pointer writes, including a value with bits 31:20 set that must be truncated. The two port models answer with different latencies, so the state machine passes through both the direct `ST_ISSUE`→`ST_RESP` path and the `ST_WAIT` path. The flash model merges byte lanes, so partial-write forwarding shows up in read data.

// File: rtl/indirect_win_pkg.sv
package indirect_win_pkg;
    localparam int WORD_W = 32;
    localparam int BE_W   = WORD_W / 8;

    typedef enum logic [1:0] {
        RGN_RM   = 2'd0,
        RGN_FL   = 2'd1,
        RGN_NONE = 2'd2
    } rgn_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } st_e;
endpackage

// File: rtl/indirect_win_ptr.sv
module indirect_win_ptr
    import indirect_win_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] wdata,
    output logic [ADDR_W-1:0] ptr_q
);
    logic unused_hi;
    assign unused_hi = ^wdata[WORD_W-1:ADDR_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= wdata[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/indirect_win_region.sv
module indirect_win_region
    import indirect_win_pkg::*;
#(
    parameter int              ADDR_W  = 20,
    parameter logic [ADDR_W-1:0] RM_LAST = 20'h1FFFF,
    parameter logic [ADDR_W-1:0] FL_BASE = 20'h80000
) (
    input  logic [ADDR_W-1:0] ptr,
    output rgn_e              rgn
);
    always_comb begin
        if (ptr <= RM_LAST)       rgn = RGN_RM;
        else if (ptr >= FL_BASE)  rgn = RGN_FL;
        else                      rgn = RGN_NONE;
    end
endmodule

// File: rtl/indirect_win_ctrl.sv
module indirect_win_ctrl
    import indirect_win_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_ok,
    input  logic              h_valid,
    input  logic              h_we,
    input  logic [4:0]        h_off,
    input  logic [BE_W-1:0]   h_be,
    input  logic [WORD_W-1:0] h_wdata,
    output logic              h_ready,
    output logic [WORD_W-1:0] h_rdata,
    input  logic [ADDR_W-1:0] ptr_q,
    input  rgn_e              rgn,
    output logic              ptr_load,
    output logic              rm_rd,
    output logic              rm_wr,
    input  logic [WORD_W-1:0] rm_rdata,
    input  logic              rm_ack,
    output logic              fl_rd,
    output logic              fl_wr,
    input  logic [WORD_W-1:0] fl_rdata,
    input  logic              fl_ack,
    output logic [BE_W-1:0]   be_q,
    output logic [WORD_W-1:0] wdata_q
);
    localparam logic [2:0]      WORD_PTR  = 3'd0;
    localparam logic [2:0]      WORD_DATA = 3'd1;
    localparam logic [BE_W-1:0] FULL_BE   = '1;

    st_e               state_q, state_d;
    logic              we_q;
    rgn_e              rgn_q;
    logic [WORD_W-1:0] resp_q, resp_d;
    logic              cap, resp_ld, ack_sel, stb;
    logic [WORD_W-1:0] rd_sel;
    logic              unused_off;

    assign unused_off = ^h_off[1:0];
    assign ack_sel    = (rgn_q == RGN_FL) ? fl_ack : rm_ack;
    assign rd_sel     = (rgn_q == RGN_FL) ? fl_rdata : rm_rdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            we_q    <= 1'b0;
            be_q    <= '0;
            wdata_q <= '0;
            rgn_q   <= RGN_NONE;
            resp_q  <= '0;
        end else begin
            state_q <= state_d;
            if (cap) begin
                we_q    <= h_we;
                be_q    <= h_be;
                wdata_q <= h_wdata;
                rgn_q   <= rgn;
            end
            if (resp_ld) resp_q <= resp_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cap      = 1'b0;
        resp_ld  = 1'b0;
        resp_d   = '0;
        ptr_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (h_valid && dec_ok) begin
                    resp_ld = 1'b1;
                    state_d = ST_RESP;
                    case (h_off[4:2])
                        WORD_PTR: begin
                            if (h_we) ptr_load = (h_be == FULL_BE);
                            else      resp_d   = WORD_W'(ptr_q);
                        end
                        WORD_DATA: begin
                            if (rgn != RGN_NONE &&
                                !(rgn == RGN_RM && h_we && h_be != FULL_BE)) begin
                                cap     = 1'b1;
                                resp_ld = 1'b0;
                                state_d = ST_ISSUE;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_ISSUE, ST_WAIT: begin
                if (ack_sel) begin
                    resp_ld = 1'b1;
                    resp_d  = we_q ? '0 : rd_sel;
                    state_d = ST_RESP;
                end else begin
                    state_d = ST_WAIT;
                end
            end
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        stb     = (state_q == ST_ISSUE);
        h_ready = (state_q == ST_RESP);
        h_rdata = h_ready ? resp_q : '0;
        rm_rd   = stb && (rgn_q == RGN_RM) && !we_q;
        rm_wr   = stb && (rgn_q == RGN_RM) &&  we_q;
        fl_rd   = stb && (rgn_q == RGN_FL) && !we_q;
        fl_wr   = stb && (rgn_q == RGN_FL) &&  we_q;
    end
endmodule

// File: rtl/indirect_win.sv
module indirect_win
    import indirect_win_pkg::*;
#(
    parameter int                ADDR_W  = 20,
    parameter logic [ADDR_W-1:0] RM_LAST = 20'h1FFFF,
    parameter logic [ADDR_W-1:0] FL_BASE = 20'h80000
) (
    input  logic              clk,
    input  logic              pwr_rst_n,
    input  logic              bus_rst_n,
    input  logic              io_base_nz,
    input  logic              io_dec_en,
    input  logic              h_valid,
    input  logic              h_we,
    input  logic [4:0]        h_off,
    input  logic [3:0]        h_be,
    input  logic [31:0]       h_wdata,
    output logic              h_ready,
    output logic [31:0]       h_rdata,
    output logic [ADDR_W-1:0] rm_addr,
    output logic              rm_rd,
    output logic              rm_wr,
    output logic [31:0]       rm_wdata,
    input  logic [31:0]       rm_rdata,
    input  logic              rm_ack,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_rd,
    output logic              fl_wr,
    output logic [3:0]        fl_be,
    output logic [31:0]       fl_wdata,
    input  logic [31:0]       fl_rdata,
    input  logic              fl_ack
);
    logic              rst_n;
    logic              ptr_load;
    logic [ADDR_W-1:0] ptr_q;
    rgn_e              rgn;
    logic [BE_W-1:0]   be_q;
    logic [WORD_W-1:0] wdata_q;

    assign rst_n = pwr_rst_n & bus_rst_n;

    indirect_win_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .wdata(h_wdata), .ptr_q(ptr_q)
    );

    indirect_win_region #(.ADDR_W(ADDR_W), .RM_LAST(RM_LAST), .FL_BASE(FL_BASE)) u_rgn (
        .ptr(ptr_q), .rgn(rgn)
    );

    indirect_win_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .dec_ok(io_base_nz & io_dec_en),
        .h_valid(h_valid), .h_we(h_we), .h_off(h_off), .h_be(h_be), .h_wdata(h_wdata),
        .h_ready(h_ready), .h_rdata(h_rdata), .ptr_q(ptr_q), .rgn(rgn), .ptr_load(ptr_load),
        .rm_rd(rm_rd), .rm_wr(rm_wr), .rm_rdata(rm_rdata), .rm_ack(rm_ack),
        .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_rdata(fl_rdata), .fl_ack(fl_ack),
        .be_q(be_q), .wdata_q(wdata_q)
    );

    assign rm_addr  = ptr_q;
    assign fl_addr  = ptr_q;
    assign rm_wdata = wdata_q;
    assign fl_wdata = wdata_q;
    assign fl_be    = be_q;
endmodule

// File: rtl/indirect_win_chk.sv
module indirect_win_chk #(
    parameter int                ADDR_W  = 20,
    parameter logic [ADDR_W-1:0] RM_LAST = 20'h1FFFF,
    parameter logic [ADDR_W-1:0] FL_BASE = 20'h80000
) (
    input logic              clk,
    input logic              pwr_rst_n,
    input logic              bus_rst_n,
    input logic              io_base_nz,
    input logic              io_dec_en,
    input logic              h_valid,
    input logic              h_we,
    input logic [4:0]        h_off,
    input logic [3:0]        h_be,
    input logic              h_ready,
    input logic [31:0]       h_rdata,
    input logic [ADDR_W-1:0] ptr_q,
    input logic              rm_rd,
    input logic              rm_wr,
    input logic              fl_rd,
    input logic              fl_wr
);
    logic any_stb;
    logic rst_ok;
    assign any_stb = rm_rd | rm_wr | fl_rd | fl_wr;
    assign rst_ok  = pwr_rst_n & bus_rst_n;

    p_ptr_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_ok)
        (h_ready && !h_we && h_off[4:2] == 3'd0) |-> (h_rdata[31:ADDR_W] == '0));

    p_no_claim_r2: assert property (@(posedge clk) disable iff (!rst_ok)
        (h_valid && !(io_base_nz && io_dec_en) && !h_ready && !any_stb) |=> !h_ready);

    p_rm_full_write_r9: assert property (@(posedge clk) disable iff (!rst_ok)
        rm_wr |-> (h_be == 4'hF));

    p_gap_silent_r10: assert property (@(posedge clk) disable iff (!rst_ok)
        (ptr_q > RM_LAST && ptr_q < FL_BASE) |-> !any_stb);

    p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_ok)
        h_ready |=> !h_ready);

    p_stb_pulse_r12: assert property (@(posedge clk) disable iff (!rst_ok)
        any_stb |=> !any_stb);

    p_stb_onehot_r12: assert property (@(posedge clk) disable iff (!rst_ok)
        $onehot0({rm_rd, rm_wr, fl_rd, fl_wr}));
endmodule

bind indirect_win indirect_win_chk #(.ADDR_W(ADDR_W), .RM_LAST(RM_LAST), .FL_BASE(FL_BASE)) u_chk (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .bus_rst_n(bus_rst_n),
    .io_base_nz(io_base_nz), .io_dec_en(io_dec_en),
    .h_valid(h_valid), .h_we(h_we), .h_off(h_off), .h_be(h_be),
    .h_ready(h_ready), .h_rdata(h_rdata), .ptr_q(ptr_q),
    .rm_rd(rm_rd), .rm_wr(rm_wr), .fl_rd(fl_rd), .fl_wr(fl_wr)
);

// File: tb/indirect_win_tb.sv
module indirect_win_tb;
    logic        clk = 1'b0;
    logic        pwr_rst_n = 1'b0, bus_rst_n = 1'b0;
    logic        io_base_nz = 1'b1, io_dec_en = 1'b1;
    logic        h_valid = 1'b0, h_we = 1'b0;
    logic [4:0]  h_off = '0;
    logic [3:0]  h_be = '0;
    logic [31:0] h_wdata = '0;
    logic        h_ready;
    logic [31:0] h_rdata;
    logic [19:0] rm_addr, fl_addr;
    logic        rm_rd, rm_wr, fl_rd, fl_wr;
    logic [31:0] rm_wdata, fl_wdata, fl_rdata;
    logic [31:0] rm_rdata;
    logic        rm_ack;
    logic [3:0]  fl_be;
    logic        fl_ack;

    always #5 clk = ~clk;

    indirect_win u_dut (
        .clk(clk), .pwr_rst_n(pwr_rst_n), .bus_rst_n(bus_rst_n),
        .io_base_nz(io_base_nz), .io_dec_en(io_dec_en),
        .h_valid(h_valid), .h_we(h_we), .h_off(h_off), .h_be(h_be), .h_wdata(h_wdata),
        .h_ready(h_ready), .h_rdata(h_rdata),
        .rm_addr(rm_addr), .rm_rd(rm_rd), .rm_wr(rm_wr), .rm_wdata(rm_wdata),
        .rm_rdata(rm_rdata), .rm_ack(rm_ack),
        .fl_addr(fl_addr), .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_be(fl_be),
        .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_ack(fl_ack)
    );

    // port models: register/memory acks one cycle after its strobe, flash acks at once
    logic [31:0] rmem [16];
    logic [31:0] fmem [16];
    always @(posedge clk) begin
        if (!pwr_rst_n) begin
            for (int i = 0; i < 16; i++) begin
                rmem[i] <= 32'hC0DE0000 + i;
                fmem[i] <= '0;
            end
            rm_ack   <= 1'b0;
            rm_rdata <= '0;
        end else begin
            rm_ack <= rm_rd | rm_wr;
            if (rm_rd) rm_rdata <= rmem[rm_addr[5:2]];
            if (rm_wr) rmem[rm_addr[5:2]] <= rm_wdata;
            if (fl_wr)
                for (int b = 0; b < 4; b++)
                    if (fl_be[b]) fmem[fl_addr[5:2]][8*b +: 8] <= fl_wdata[8*b +: 8];
        end
    end
    assign fl_rdata = fmem[fl_addr[5:2]];
    assign fl_ack   = fl_rd | fl_wr;

    int stb_cnt = 0;
    always @(posedge clk) if (rm_rd | rm_wr | fl_rd | fl_wr) stb_cnt <= stb_cnt + 1;

    int n_chk = 0, n_bad = 0;
    logic [31:0] rd_v;
    int cyc_v, stb_v;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xact(input logic we, input logic [4:0] off, input logic [3:0] be,
                        input logic [31:0] wd);
        int s0;
        @(negedge clk);
        s0 = stb_cnt;
        h_valid = 1'b1; h_we = we; h_off = off; h_be = be; h_wdata = wd;
        cyc_v = 0; rd_v = 'x;
        forever begin
            @(posedge clk); #1;
            cyc_v++;
            if (h_ready) begin rd_v = h_rdata; break; end
            if (cyc_v > 40) break;
        end
        @(negedge clk);
        h_valid = 1'b0;
        stb_v = stb_cnt - s0;
    endtask

    typedef struct packed {
        logic        we;
        logic [4:0]  off;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        chk;
        logic [1:0]  stb;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 5'h00, 4'hF, 32'h00000010, 32'h0,        1'b0, 2'd0}, // R3 load
        '{1'b0, 5'h00, 4'h1, 32'h0,        32'h00000010, 1'b1, 2'd0}, // R3 R6 narrow read
        '{1'b1, 5'h04, 4'hF, 32'hA5A50001, 32'h0,        1'b0, 2'd1}, // R7 write
        '{1'b0, 5'h04, 4'h1, 32'h0,        32'hA5A50001, 1'b1, 2'd1}, // R7 R6 read
        '{1'b1, 5'h00, 4'h3, 32'h00000123, 32'h0,        1'b0, 2'd0}, // R4 narrow ptr write
        '{1'b0, 5'h00, 4'hF, 32'h0,        32'h00000010, 1'b1, 2'd0}, // R4 unchanged
        '{1'b1, 5'h00, 4'hF, 32'hFFF80008, 32'h0,        1'b0, 2'd0}, // R3 upper bits
        '{1'b0, 5'h00, 4'hF, 32'h0,        32'h00080008, 1'b1, 2'd0}, // R3 read back
        '{1'b1, 5'h04, 4'hF, 32'h11223344, 32'h0,        1'b0, 2'd1}, // R8 full
        '{1'b1, 5'h04, 4'h2, 32'hAABBCCDD, 32'h0,        1'b0, 2'd1}, // R8 partial lane 1
        '{1'b0, 5'h04, 4'hF, 32'h0,        32'h1122CC44, 1'b1, 2'd1}, // R8 merged
        '{1'b1, 5'h08, 4'hF, 32'hDEADBEEF, 32'h0,        1'b0, 2'd0}, // R1 unused write
        '{1'b0, 5'h08, 4'hF, 32'h0,        32'h0,        1'b1, 2'd0}, // R1 unused read
        '{1'b0, 5'h00, 4'hF, 32'h0,        32'h00080008, 1'b1, 2'd0}, // R1 ptr untouched
        '{1'b1, 5'h00, 4'hF, 32'h00030000, 32'h0,        1'b0, 2'd0}, // R10 gap
        '{1'b0, 5'h04, 4'hF, 32'h0,        32'h0,        1'b1, 2'd0}, // R10 read zero
        '{1'b1, 5'h04, 4'hF, 32'h5555AAAA, 32'h0,        1'b0, 2'd0}, // R10 write silent
        '{1'b1, 5'h00, 4'hF, 32'h00000004, 32'h0,        1'b0, 2'd0}, // R9 setup
        '{1'b1, 5'h04, 4'h7, 32'h12345678, 32'h0,        1'b0, 2'd0}, // R9 dropped
        '{1'b0, 5'h04, 4'hF, 32'h0,        32'hC0DE0001, 1'b1, 2'd1}  // R9 memory intact
    };

    task automatic no_claim(input string req);
        int s0;
        @(negedge clk);
        s0 = stb_cnt;
        h_valid = 1'b1; h_we = 1'b1; h_off = 5'h00; h_be = 4'hF; h_wdata = 32'h00000040;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            check(req, {31'd0, h_ready}, 32'd0);
        end
        @(negedge clk);
        h_valid = 1'b0;
        check(req, stb_cnt - s0, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        pwr_rst_n = 1'b1; bus_rst_n = 1'b1;

        xact(1'b0, 5'h00, 4'hF, 32'h0);
        check("R5 reset value", rd_v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            xact(TBL[i].we, TBL[i].off, TBL[i].be, TBL[i].wd);
            if (TBL[i].chk) check($sformatf("R6 row %0d rdata", i), rd_v, TBL[i].exp);
            check($sformatf("R12 row %0d strobes", i), stb_v, 32'(TBL[i].stb));
        end

        // R11 latency per path
        xact(1'b1, 5'h00, 4'hF, 32'h00000010);
        check("R11 local latency", cyc_v, 1);
        xact(1'b0, 5'h04, 4'hF, 32'h0);
        check("R11 rm latency", cyc_v, 3);
        check("R7 rm read", rd_v, 32'hA5A50001);
        xact(1'b1, 5'h00, 4'hF, 32'h00080008);
        xact(1'b0, 5'h04, 4'hF, 32'h0);
        check("R11 flash latency", cyc_v, 2);

        // R2 decode gating
        io_dec_en = 1'b0;
        no_claim("R2 decode off");
        io_dec_en = 1'b1; io_base_nz = 1'b0;
        no_claim("R2 base zero");
        io_base_nz = 1'b1;
        xact(1'b0, 5'h00, 4'hF, 32'h0);
        check("R2 ptr kept", rd_v, 32'h00080008);

        // R5 each reset source
        @(negedge clk); bus_rst_n = 1'b0;
        @(negedge clk); bus_rst_n = 1'b1;
        xact(1'b0, 5'h00, 4'hF, 32'h0);
        check("R5 bus reset", rd_v, 32'h0);
        xact(1'b1, 5'h00, 4'hF, 32'h00000020);
        @(negedge clk); pwr_rst_n = 1'b0;
        @(negedge clk); pwr_rst_n = 1'b1;
        xact(1'b0, 5'h00, 4'hF, 32'h0);
        check("R5 power reset", rd_v, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule